// File: doc/BRIEF.md
# Synthesizer Channel Post-Divider

This block is the last stage of one frequency-synthesizer channel. It receives a fast clock-enable stream and produces a slower clock-enable: a single-cycle pulse on every N-th input enable. The total ratio N is a power of two chosen by a divider code. An optional extra divide by three follows it, and it is selected by an active-low control. An active-low standby input silences the output and returns the division to a known starting phase.

Software-style programming is decoupled from the running output. The code and the divide-by-three control are captured only in a cycle where the commit strobe is high. The captured values wait in a pending slot. They become the active settings only when the output period in progress has ended, or at once while the channel is in standby. Because of this, no shortened or stretched period is ever produced. A parameter selects how the code is read: a 3-bit code with an offset of one, or a 4-bit code used directly. Everything runs on one clock with a synchronous, active-high reset.

Top module: `synth_postdiv`

## Requirements
- R1: While `rst` is high, `div_en_out` is 0. After reset the active settings are code 0 with the divide by three bypassed, which gives a ratio of 2 in the narrow variant and 1 in the wide variant. No pending setting survives reset.
- R2: With `WIDE_CODE` = 0, `code_in` is 3 bits wide and the power-of-two ratio is 2^(code+1), which covers 2 to 256.
- R3: With `WIDE_CODE` = 1, `code_in` is 4 bits wide and the power-of-two ratio is 2^code, which covers 1 to 32768.
- R4: An active `ndiv3_in` value of 0 multiplies the ratio by 3. A value of 1 bypasses the divide by three.
- R5: `div_en_out` is high for exactly one cycle on every N-th cycle in which `clk_en_in` is high, where N is the total active ratio. It is never high in a cycle where `clk_en_in` is low, and no pulse is missed.
- R6: While `nstby_in` is 0, `div_en_out` is 0 and the division state is cleared.
- R7: After `nstby_in` returns to 1, the first pulse falls on the N-th input enable, counted from the first enable seen in run.
- R8: `code_in` and `ndiv3_in` are sampled only in a cycle with `commit_in` high. Changing them in any other cycle has no effect on the output.
- R9: A committed setting becomes active at the clock edge that ends the cycle of an output pulse. In standby it becomes active at the next clock edge. A newer commit made before adoption replaces the older one. The period in progress always completes with the old ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_in | input | 1 | Input clock-enable stream to be divided |
| nstby_in | input | 1 | Standby control, active low (0 = standby) |
| commit_in | input | 1 | Commit strobe that captures the divider settings |
| code_in | input | 3 (WIDE_CODE=0) or 4 | Power-of-two divider code |
| ndiv3_in | input | 1 | Divide-by-three control, active low (0 = divide by 3) |
| div_en_out | output | 1 | Divided enable, one-cycle pulse per period |

## Verification
The assertions check every cycle for the following properties:
- Standby clears the counters and keeps the output low.
- A pulse only ever accompanies an input enable.
- The counters stay inside the active ratio.
- Two pulses never come back to back unless the ratio is one.
- The first cycle after standby fires only for a ratio of one.
- Active settings change only when a commit is pending and a period boundary or standby allows it.

The exact period length for every code and divide-by-three combination can only be shown by the bench scenarios. The same holds for the restart phase after standby, for the old ratio completing before the new one takes over, and for the lack of effect of uncommitted input changes. The bench measures these by counting input enables between pulses.

// File: rtl/postdiv_pkg.sv
package postdiv_pkg;

  // Phase of the divide-by-three stage.
  typedef enum logic [1:0] {
    M3_A = 2'd0,
    M3_B = 2'd1,
    M3_C = 2'd2
  } m3_phase_t;

  // Shift amount of the power-of-two stage for a zero-extended code.
  // Narrow variant: code plus one; wide variant: code as is.
  function automatic logic [4:0] pd_shift(input logic [3:0] code, input bit wide);
    logic [4:0] sh;
    sh = {1'b0, code};
    if (!wide) sh = sh + 5'd1;
    return sh;
  endfunction

endpackage

// File: rtl/postdiv_cfg.sv
module postdiv_cfg #(
  parameter int CodeW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_in,
  input  logic [CodeW-1:0] code_in,
  input  logic             ndiv3_in,
  input  logic             boundary,
  output logic [CodeW-1:0] act_code,
  output logic             act_ndiv3,
  output logic             pend_valid,
  output logic             adopt
);

  logic [CodeW-1:0] pend_code;
  logic             pend_ndiv3;

  assign adopt = pend_valid & boundary;

  // Pending slot: loaded only on commit.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_code  <= '0;
      pend_ndiv3 <= 1'b1;
      pend_valid <= 1'b0;
    end else if (commit_in) begin
      pend_code  <= code_in;
      pend_ndiv3 <= ndiv3_in;
      pend_valid <= 1'b1;
    end else if (adopt) begin
      pend_valid <= 1'b0;
    end
  end

  // Active settings: copied from the pending slot at a safe boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_code  <= '0;
      act_ndiv3 <= 1'b1;
    end else if (adopt) begin
      act_code  <= pend_code;
      act_ndiv3 <= pend_ndiv3;
    end
  end

endmodule

// File: rtl/postdiv_p2.sv
module postdiv_p2 #(
  parameter int P2W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           en,
  input  logic [P2W-1:0] mask,
  output logic [P2W-1:0] cnt,
  output logic           wrap
);

  logic last;

  assign last = (cnt == mask);
  assign wrap = run & en & last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/postdiv_m3.sv
module postdiv_m3
  import postdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      run,
  input  logic      step,
  input  logic      bypass,
  output m3_phase_t phase,
  output logic      fire
);

  logic at_end;

  assign at_end = bypass | (phase == M3_C);
  assign fire   = step & at_end;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase <= M3_A;
    end else if (step) begin
      if (at_end) begin
        phase <= M3_A;
      end else begin
        case (phase)
          M3_A:    phase <= M3_B;
          M3_B:    phase <= M3_C;
          default: phase <= M3_A;
        endcase
      end
    end
  end

endmodule

// File: rtl/synth_postdiv.sv
module synth_postdiv
  import postdiv_pkg::*;
#(
  parameter bit WIDE_CODE = 1'b0
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clk_en_in,
  input  logic                            nstby_in,
  input  logic                            commit_in,
  input  logic [(WIDE_CODE ? 4 : 3)-1:0]  code_in,
  input  logic                            ndiv3_in,
  output logic                            div_en_out
);

  localparam int CodeW = WIDE_CODE ? 4 : 3;
  localparam int P2W   = WIDE_CODE ? 15 : 8;

  // Low-order ones for a given shift; a full shift yields all ones.
  function automatic logic [P2W-1:0] mask_of(input logic [4:0] sh);
    logic [P2W-1:0] ones;
    ones = '1;
    return ~(ones << sh);
  endfunction

  // Named internal events, also observed by the checker.
  logic             run;
  logic             boundary;
  logic             adopt;
  logic             pend_valid;
  logic [CodeW-1:0] act_code;
  logic             act_ndiv3;
  logic [3:0]       code4;
  logic [4:0]       shift;
  logic [P2W-1:0]   p2_mask;
  logic [P2W-1:0]   p2_cnt;
  logic             p2_wrap;
  m3_phase_t        m3_phase;
  logic             fire;

  assign run      = nstby_in & ~rst;
  assign boundary = fire | ~run;

  postdiv_cfg #(.CodeW(CodeW)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .commit_in  (commit_in),
    .code_in    (code_in),
    .ndiv3_in   (ndiv3_in),
    .boundary   (boundary),
    .act_code   (act_code),
    .act_ndiv3  (act_ndiv3),
    .pend_valid (pend_valid),
    .adopt      (adopt)
  );

  generate
    if (CodeW < 4) begin : g_narrow
      assign code4 = {{(4 - CodeW){1'b0}}, act_code};
    end else begin : g_wide
      assign code4 = act_code;
    end
  endgenerate

  assign shift   = pd_shift(code4, WIDE_CODE);
  assign p2_mask = mask_of(shift);

  postdiv_p2 #(.P2W(P2W)) u_p2 (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .en   (clk_en_in),
    .mask (p2_mask),
    .cnt  (p2_cnt),
    .wrap (p2_wrap)
  );

  postdiv_m3 u_m3 (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .step   (p2_wrap),
    .bypass (act_ndiv3),
    .phase  (m3_phase),
    .fire   (fire)
  );

  assign div_en_out = fire;

endmodule

// File: rtl/postdiv_checker.sv
module postdiv_checker
  import postdiv_pkg::*;
#(
  parameter int CodeW = 3,
  parameter int P2W   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clk_en_in,
  input logic             nstby_in,
  input logic             div_en_out,
  input logic             run,
  input logic             pend_valid,
  input logic [CodeW-1:0] act_code,
  input logic             act_ndiv3,
  input logic [P2W-1:0]   p2_mask,
  input logic [P2W-1:0]   p2_cnt,
  input m3_phase_t        m3_phase
);

  p_stby_clears_r6: assert property (@(posedge clk) disable iff (rst)
    !nstby_in |=> (p2_cnt == '0) && (m3_phase == M3_A));

  p_stby_silent_r6: assert property (@(posedge clk) disable iff (rst)
    !nstby_in |-> !div_en_out);

  p_pulse_has_en_r5: assert property (@(posedge clk) disable iff (rst)
    div_en_out |-> clk_en_in);

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
    (p2_cnt <= p2_mask) && (m3_phase != 2'd3));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    div_en_out && !pend_valid && (p2_mask != '0) |=> !div_en_out);

  p_restart_phase_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!nstby_in) && nstby_in && div_en_out |-> (p2_mask == '0) && act_ndiv3);

  p_adopt_boundary_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable({act_code, act_ndiv3}) |-> $past(div_en_out || !run));

  p_adopt_needs_commit_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable({act_code, act_ndiv3}) |-> $past(pend_valid));

endmodule

bind synth_postdiv postdiv_checker #(.CodeW(CodeW), .P2W(P2W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clk_en_in  (clk_en_in),
  .nstby_in   (nstby_in),
  .div_en_out (div_en_out),
  .run        (run),
  .pend_valid (pend_valid),
  .act_code   (act_code),
  .act_ndiv3  (act_ndiv3),
  .p2_mask    (p2_mask),
  .p2_cnt     (p2_cnt),
  .m3_phase   (m3_phase)
);

// File: tb/tb_synth_postdiv.sv
module tb_synth_postdiv;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic       rst, clk_en, nstby, commit, nd;
  logic [2:0] code_n;
  logic [3:0] code_w;
  logic       out_n, out_w;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;
  int dens = 100;
  bit scr = 0;

  // Bench model state, index 0 = narrow, 1 = wide.
  int cnt[2];
  int expv[2];
  int nxt[2];
  int first[2];
  bit pend[2];
  bit adopted[2];

  synth_postdiv #(.WIDE_CODE(1'b0)) dut (
    .clk(clk), .rst(rst), .clk_en_in(clk_en), .nstby_in(nstby),
    .commit_in(commit), .code_in(code_n), .ndiv3_in(nd), .div_en_out(out_n));

  synth_postdiv #(.WIDE_CODE(1'b1)) dut_w (
    .clk(clk), .rst(rst), .clk_en_in(clk_en), .nstby_in(nstby),
    .commit_in(commit), .code_in(code_w), .ndiv3_in(nd), .div_en_out(out_w));

  // Expected ratio restated from R2, R3, R4.
  function automatic int ratio_of(int k, int code, bit ndv);
    int p;
    p = 1;
    for (int i = 0; i < code + (k == 0 ? 1 : 0); i++) p = p * 2;
    return ndv ? p : p * 3;
  endfunction

  task automatic check(bit ok, string tag, int act, int expd);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expd);
    end
  endtask

  // Monitor: sample away from the active edge, after the negedge drive.
  always @(negedge clk) begin
    logic [1:0] o;
    string tag;
    #1;
    o = {out_w, out_n};
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        check(o[k] == 1'b0, "R1 out in reset", o[k], 0);
        cnt[k] = 0; pend[k] = 0; adopted[k] = 0; first[k] = 1;
        expv[k] = (k == 0) ? 2 : 1;
      end else if (!nstby) begin
        check(o[k] == 1'b0, "R6 out in standby", o[k], 0);
        cnt[k] = 0;
        if (pend[k]) begin expv[k] = nxt[k]; pend[k] = 0; end
        first[k] = 2;
      end else begin
        if (o[k] && !clk_en) check(1'b0, "R5 pulse without enable", 1, 0);
        if (clk_en) cnt[k]++;
        if (o[k]) begin
          if (first[k] == 1) tag = "R1 default period";
          else if (first[k] == 2) tag = "R7 first period after standby";
          else if (adopted[k]) tag = "R9 period after adoption";
          else if (expv[k] % 3 == 0) tag = "R4 period with divide by 3";
          else tag = (k == 0) ? "R2 narrow period" : "R3 wide period";
          check(cnt[k] == expv[k], tag, cnt[k], expv[k]);
          cnt[k] = 0; first[k] = 0; adopted[k] = 0;
          if (pend[k]) begin expv[k] = nxt[k]; pend[k] = 0; adopted[k] = 1; end
        end else if (clk_en && cnt[k] >= expv[k]) begin
          check(1'b0, "R5 missing pulse", cnt[k], expv[k]);
          cnt[k] = 0;
        end
      end
      if (!rst && commit) begin
        pend[k] = 1;
        nxt[k] = (k == 0) ? ratio_of(0, int'(code_n), nd) : ratio_of(1, int'(code_w), nd);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      commit = 1'b0;
      clk_en = (($urandom % 100) < dens);
      if (scr) begin   // R8: uncommitted changes on the setting inputs
        code_n = 3'($urandom);
        code_w = 4'($urandom);
        nd     = 1'($urandom);
      end
    end
  endtask

  task automatic do_commit(int cn, int cw, bit ndv);
    @(negedge clk);
    commit = 1'b1;
    code_n = 3'(cn);
    code_w = 4'(cw);
    nd     = ndv;
    clk_en = (($urandom % 100) < dens);
  endtask

  task automatic run_cfg(int cn, int cw, bit ndv, int cycles, int d);
    dens = d;
    tick(1);
    nstby = 1'b0;
    tick(2);
    do_commit(cn, cw, ndv);
    tick(3);
    nstby = 1'b1;
    tick(cycles);
  endtask

  initial begin
    void'($urandom(32'd7321));
    rst = 1'b1; nstby = 1'b1; clk_en = 1'b1; commit = 1'b0; nd = 1'b1;
    code_n = '0; code_w = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tick(20);                                   // R1 default ratios

    scr = 1'b1;
    for (int cn = 0; cn < 8; cn++) begin        // R2, R3, R4, R7 sweep
      for (int b = 0; b < 2; b++) begin
        run_cfg(cn, cn, b[0], (ratio_of(0, cn, b[0]) * 4) + 16, 75);
      end
    end
    for (int cw = 8; cw < 11; cw++) begin       // R3 larger wide codes
      for (int b = 0; b < 2; b++) begin
        run_cfg(int'($urandom % 8), cw, b[0], (ratio_of(1, cw, b[0]) * 5) / 2 + 8, 100);
      end
    end

    run_cfg(1, 2, 1'b1, 20, 60);                // R9 commits while running
    for (int i = 0; i < 40; i++) begin
      tick(int'($urandom % 30) + 1);
      do_commit(int'($urandom % 4), int'($urandom % 6), 1'($urandom));
    end
    tick(400);

    for (int i = 0; i < 12; i++) begin          // R6, R7 standby mid-period
      tick(int'($urandom % 50) + 5);
      nstby = 1'b0;
      if (i % 3 == 0) do_commit(int'($urandom % 3), int'($urandom % 4), 1'($urandom));
      tick(int'($urandom % 4) + 1);
      nstby = 1'b1;
    end
    tick(300);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule